// File: doc/BRIEF.md
# Reservation monitor for load-reserved / store-conditional

This block lets two requesting cores perform atomic read-modify-write sequences on a shared, word-addressed memory that the block contains. A core reads a word with a load-reserved request, which also arms a reservation on that address for that core. The core later sends a store-conditional to the same address. The write is performed, and success is reported, only if the reservation is still armed. A store by the other core to the reserved word disarms the reservation, so the losing core gets a failure code, sees that memory is unchanged, and retries. No update is lost.

Each core has its own request port, which carries an operation, an address and write data, and its own response port. Plain loads and stores are also accepted. Every request receives exactly one response one cycle later. When both cores request in the same cycle, core 0's access is applied first and core 1 sees its effects. Compare-and-swap is built in software from the pair: the core loads with reservation, compares the value with the expected one, and issues the store-conditional only on a match.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserved (op code 2) responds with the word's current value, including a write made earlier in the same cycle by a higher-priority core.
- R2: A load-reserved arms a reservation for that core on the address. A later store-conditional (op code 3) by that core to that address, with no foreign write in between, writes memory and responds with 0.
- R3: A store-conditional with no armed reservation responds with 1 and leaves memory unchanged.
- R4: A write by one core (a plain store, or a successful store-conditional) to an address another core has reserved disarms that other core's reservation. The exception is a same-cycle load-reserved by the other core that is applied after the write.
- R5: A store-conditional always disarms the issuing core's own reservation, on success and on failure, so a second store-conditional fails.
- R6: A store-conditional to an address other than the reserved one responds with 1 and writes nothing.
- R7: Requests in the same cycle are applied in fixed order, core 0 first. When both cores send store-conditionals to a word both have reserved, core 0 succeeds and core 1 fails.
- R8: A plain load (op code 0) returns the stored word. A plain store (op code 1) writes and responds with 0. Each response is valid exactly one cycle after its request, and no response appears without a request.
- R9: Reset (active low, asynchronous) clears every memory word to 0, disarms all reservations and drops every response valid.
- R10: Two cores that increment a shared counter through retried load-reserved/store-conditional sequences take it from 5 to 6 to 7 without losing an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NC | Request valid, one bit per core |
| req_op_i | input | NC x 2 | Operation per core: 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr_i | input | NC x AW | Word address per core |
| req_wdata_i | input | NC x DW | Write data per core |
| rsp_valid_o | output | NC | Response valid per core |
| rsp_rdata_o | output | NC x DW | Read data for loads; status for stores (0 success, 1 failure) |

## Verification
Each response, whether read data or status, is registered and is due on the clock edge that follows its request. The bench drives inputs on a falling edge and samples the responses on the next falling edge, exactly one rising edge later. It also compares the response-valid bits against the request-valid bits in every step. Effects on memory and on reservations become visible to a request issued in the following cycle, or within the same cycle to the lower-priority core. The bench therefore checks them through a follow-up load or store-conditional in the next step, or through same-cycle pairs of core 0 and core 1.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LRES  = 2'd2,
    OP_SCOND = 2'd3
  } op_e;

  localparam int unsigned SC_PASS = 0;
  localparam int unsigned SC_FAIL = 1;
endpackage

// File: rtl/lrsc_word_mem.sv
module lrsc_word_mem #(
  parameter int unsigned NC = 2,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NC-1:0][AW-1:0] rd_addr_i,
  output logic [NC-1:0][DW-1:0] rd_data_o,
  input  logic [NC-1:0]         wr_en_i,
  input  logic [NC-1:0][AW-1:0] wr_addr_i,
  input  logic [NC-1:0][DW-1:0] wr_data_i
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // later core index wins: it is applied after the lower ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (wr_en_i[c]) mem_q[wr_addr_i[c]] <= wr_data_i[c];
      end
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_rd
    assign rd_data_o[c] = mem_q[rd_addr_i[c]];
  end
endmodule

// File: rtl/lrsc_resv_regs.sv
module lrsc_resv_regs #(
  parameter int unsigned NC = 2,
  parameter int unsigned AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NC-1:0]         nxt_vld_i,
  input  logic [NC-1:0][AW-1:0] nxt_addr_i,
  output logic [NC-1:0]         vld_o,
  output logic [NC-1:0][AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= '0;
      addr_o <= '0;
    end else begin
      vld_o  <= nxt_vld_i;
      addr_o <= nxt_addr_i;
    end
  end
endmodule

// File: rtl/lrsc_order_unit.sv
module lrsc_order_unit
  import lrsc_pkg::*;
#(
  parameter int unsigned NC = 2,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic [NC-1:0]         req_valid_i,
  input  logic [NC-1:0][1:0]    req_op_i,
  input  logic [NC-1:0][AW-1:0] req_addr_i,
  input  logic [NC-1:0][DW-1:0] req_wdata_i,
  input  logic [NC-1:0][DW-1:0] mem_rd_i,
  input  logic [NC-1:0]         resv_vld_i,
  input  logic [NC-1:0][AW-1:0] resv_addr_i,
  output logic [NC-1:0]         wr_en_o,
  output logic [NC-1:0][AW-1:0] wr_addr_o,
  output logic [NC-1:0][DW-1:0] wr_data_o,
  output logic [NC-1:0][DW-1:0] rsp_data_o,
  output logic [NC-1:0]         nxt_vld_o,
  output logic [NC-1:0][AW-1:0] nxt_addr_o
);
  logic [NC-1:0]         ld_c, st_c, lr_c, sc_c;
  logic [NC-1:0]         seen_vld, sc_ok, we_v;
  logic [NC-1:0][DW-1:0] rd_fwd;

  for (genvar c = 0; c < NC; c++) begin : g_dec
    assign ld_c[c] = req_valid_i[c] && (req_op_i[c] == OP_LOAD);
    assign st_c[c] = req_valid_i[c] && (req_op_i[c] == OP_STORE);
    assign lr_c[c] = req_valid_i[c] && (req_op_i[c] == OP_LRES);
    assign sc_c[c] = req_valid_i[c] && (req_op_i[c] == OP_SCOND);
  end

  // apply accesses in index order; each core sees the writes of lower ones
  always_comb begin
    we_v       = '0;
    rd_fwd     = '0;
    seen_vld   = '0;
    sc_ok      = '0;
    rsp_data_o = '0;
    for (int i = 0; i < NC; i++) begin
      rd_fwd[i]   = mem_rd_i[i];
      seen_vld[i] = resv_vld_i[i];
      for (int j = 0; j < i; j++) begin
        if (we_v[j] && req_addr_i[j] == req_addr_i[i]) rd_fwd[i] = req_wdata_i[j];
        if (we_v[j] && req_addr_i[j] == resv_addr_i[i]) seen_vld[i] = 1'b0;
      end
      sc_ok[i] = sc_c[i] && seen_vld[i] && (resv_addr_i[i] == req_addr_i[i]);
      we_v[i]  = st_c[i] || sc_ok[i];
      if (sc_c[i])
        rsp_data_o[i] = sc_ok[i] ? DW'(SC_PASS) : DW'(SC_FAIL);
      else if (ld_c[i] || lr_c[i])
        rsp_data_o[i] = rd_fwd[i];
      else
        rsp_data_o[i] = '0;
    end
  end

  // next reservations: own op first, then kills by other cores' writes
  always_comb begin
    nxt_vld_o  = '0;
    nxt_addr_o = '0;
    for (int i = 0; i < NC; i++) begin
      if (lr_c[i]) begin
        nxt_vld_o[i]  = 1'b1;
        nxt_addr_o[i] = req_addr_i[i];
      end else begin
        nxt_vld_o[i]  = sc_c[i] ? 1'b0 : resv_vld_i[i];
        nxt_addr_o[i] = resv_addr_i[i];
      end
      for (int j = 0; j < NC; j++) begin
        if (j != i && we_v[j] && req_addr_i[j] == nxt_addr_o[i] && (j > i || !lr_c[i]))
          nxt_vld_o[i] = 1'b0;
      end
    end
  end

  assign wr_en_o   = we_v;
  assign wr_addr_o = req_addr_i;
  assign wr_data_o = req_wdata_i;
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned NC = 2,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NC-1:0]         req_valid_i,
  input  logic [NC-1:0][1:0]    req_op_i,
  input  logic [NC-1:0][AW-1:0] req_addr_i,
  input  logic [NC-1:0][DW-1:0] req_wdata_i,
  output logic [NC-1:0]         rsp_valid_o,
  output logic [NC-1:0][DW-1:0] rsp_rdata_o
);
  logic [NC-1:0][DW-1:0] mem_rd;
  logic [NC-1:0]         wr_en;
  logic [NC-1:0][AW-1:0] wr_addr;
  logic [NC-1:0][DW-1:0] wr_data;
  logic [NC-1:0][DW-1:0] rsp_data;
  logic [NC-1:0]         resv_vld, nxt_vld;
  logic [NC-1:0][AW-1:0] resv_addr, nxt_addr;

  lrsc_word_mem #(.NC(NC), .AW(AW), .DW(DW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (req_addr_i),
    .rd_data_o (mem_rd),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  lrsc_resv_regs #(.NC(NC), .AW(AW)) u_resv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nxt_vld_i  (nxt_vld),
    .nxt_addr_i (nxt_addr),
    .vld_o      (resv_vld),
    .addr_o     (resv_addr)
  );

  lrsc_order_unit #(.NC(NC), .AW(AW), .DW(DW)) u_order (
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_rd_i    (mem_rd),
    .resv_vld_i  (resv_vld),
    .resv_addr_i (resv_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rsp_data_o  (rsp_data),
    .nxt_vld_o   (nxt_vld),
    .nxt_addr_o  (nxt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rsp_data;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk
  import lrsc_pkg::*;
#(
  parameter int unsigned NC = 2,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NC-1:0]         req_valid_i,
  input logic [NC-1:0][1:0]    req_op_i,
  input logic [NC-1:0][AW-1:0] req_addr_i,
  input logic [NC-1:0]         rsp_valid_o,
  input logic [NC-1:0][DW-1:0] rsp_rdata_o,
  input logic [NC-1:0]         resv_vld,
  input logic [NC-1:0][AW-1:0] resv_addr,
  input logic [NC-1:0]         wr_en
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (resv_vld == '0 && rsp_valid_o == '0); // R9
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_core
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i[i] |=> rsp_valid_o[i]); // R8
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i[i] |=> !rsp_valid_o[i]); // R8
    AST_SC_DROPS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[i] && req_op_i[i] == OP_SCOND) |=> !resv_vld[i]); // R5
    for (genvar j = 0; j < NC; j++) begin : g_other
      if (j != i) begin : g_kill
        AST_FOREIGN_WRITE_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (resv_vld[i] && wr_en[j] && req_addr_i[j] == resv_addr[i] &&
           !(req_valid_i[i] && req_op_i[i] == OP_LRES)) |=> !resv_vld[i]); // R4
      end
    end
  end

  AST_LR_ARMS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i[NC-1] && req_op_i[NC-1] == OP_LRES) |=>
      (resv_vld[NC-1] && resv_addr[NC-1] == $past(req_addr_i[NC-1]))); // R2

  AST_SC_NO_RESV_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i[0] && req_op_i[0] == OP_SCOND && !resv_vld[0]) |=>
      rsp_rdata_o[0] == DW'(SC_FAIL)); // R3

  AST_SC_WRONG_ADDR_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i[0] && req_op_i[0] == OP_SCOND && resv_vld[0] &&
     resv_addr[0] != req_addr_i[0]) |=> rsp_rdata_o[0] == DW'(SC_FAIL)); // R6
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NC(NC), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .resv_vld    (resv_vld),
  .resv_addr   (resv_addr),
  .wr_en       (wr_en)
);

// File: tb/tb_lrsc_monitor.sv
`timescale 1ns/1ps
module tb_lrsc_monitor;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;
  localparam logic [31:0] OK = 32'd0, NG = 32'd1;

  typedef struct packed {
    logic [23:0] tag;
    logic        v0;
    logic [1:0]  o0;
    logic [3:0]  a0;
    logic [31:0] d0;
    logic        v1;
    logic [1:0]  o1;
    logic [3:0]  a1;
    logic [31:0] d1;
    logic [31:0] x0;
    logic [31:0] x1;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{"R8 ", 1'b1, ST, 4'd3, 32'd5,  1'b0, LD, 4'd0, 32'd0,  OK,     32'd0},
    '{"R8 ", 1'b1, LD, 4'd3, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd5,  32'd0},
    '{"R1 ", 1'b1, LR, 4'd3, 32'd0,  1'b1, LR, 4'd3, 32'd0,  32'd5,  32'd5},
    '{"R2 ", 1'b1, SC, 4'd3, 32'd6,  1'b0, LD, 4'd0, 32'd0,  OK,     32'd0},
    '{"R4 ", 1'b0, LD, 4'd0, 32'd0,  1'b1, SC, 4'd3, 32'd6,  32'd0,  NG},
    '{"R10", 1'b0, LD, 4'd0, 32'd0,  1'b1, LR, 4'd3, 32'd0,  32'd0,  32'd6},
    '{"R10", 1'b0, LD, 4'd0, 32'd0,  1'b1, SC, 4'd3, 32'd7,  32'd0,  OK},
    '{"R10", 1'b1, LD, 4'd3, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd7,  32'd0},
    '{"R5 ", 1'b1, SC, 4'd3, 32'd9,  1'b0, LD, 4'd0, 32'd0,  NG,     32'd0},
    '{"R3 ", 1'b1, LD, 4'd3, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd7,  32'd0},
    '{"R1 ", 1'b1, LR, 4'd4, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd0,  32'd0},
    '{"R6 ", 1'b1, SC, 4'd5, 32'd11, 1'b0, LD, 4'd0, 32'd0,  NG,     32'd0},
    '{"R6 ", 1'b1, LD, 4'd5, 32'd0,  1'b1, LD, 4'd4, 32'd0,  32'd0,  32'd0},
    '{"R7 ", 1'b1, LR, 4'd4, 32'd0,  1'b1, LR, 4'd4, 32'd0,  32'd0,  32'd0},
    '{"R7 ", 1'b1, SC, 4'd4, 32'd20, 1'b1, SC, 4'd4, 32'd21, OK,     NG},
    '{"R7 ", 1'b1, LD, 4'd4, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd20, 32'd0},
    '{"R1 ", 1'b1, ST, 4'd6, 32'd33, 1'b1, LD, 4'd6, 32'd0,  OK,     32'd33},
    '{"R7 ", 1'b1, ST, 4'd6, 32'd44, 1'b1, LR, 4'd6, 32'd0,  OK,     32'd44},
    '{"R7 ", 1'b0, LD, 4'd0, 32'd0,  1'b1, SC, 4'd6, 32'd45, 32'd0,  OK},
    '{"R4 ", 1'b1, LR, 4'd7, 32'd0,  1'b1, ST, 4'd7, 32'd3,  32'd0,  OK},
    '{"R4 ", 1'b1, SC, 4'd7, 32'd8,  1'b0, LD, 4'd0, 32'd0,  NG,     32'd0},
    '{"R4 ", 1'b1, LD, 4'd7, 32'd0,  1'b0, LD, 4'd0, 32'd0,  32'd3,  32'd0}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       req_valid = '0;
  logic [1:0][1:0]  req_op = '0;
  logic [1:0][3:0]  req_addr = '0;
  logic [1:0][31:0] req_wdata = '0;
  logic [1:0]       rsp_valid;
  logic [1:0][31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lrsc_monitor #(.NC(2), .AW(4), .DW(32)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  task automatic check(input logic [23:0] tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=0x%08h exp=0x%08h", tag, what, got, exp);
    end
  endtask

  // drive on a falling edge, check on the next falling edge
  task automatic do_step(input vec_t v);
    req_valid    = {v.v1, v.v0};
    req_op[0]    = v.o0;  req_op[1]    = v.o1;
    req_addr[0]  = v.a0;  req_addr[1]  = v.a1;
    req_wdata[0] = v.d0;  req_wdata[1] = v.d1;
    @(negedge clk);
    check(v.tag, "rsp_valid", {30'd0, rsp_valid}, {30'd0, v.v1, v.v0});
    if (v.v0) check(v.tag, "core0 data", rsp_rdata[0], v.x0);
    if (v.v1) check(v.tag, "core1 data", rsp_rdata[1], v.x1);
    req_valid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 ", "reset rsp_valid", {30'd0, rsp_valid}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_step('{"R9 ", 1'b1, LD, 4'd0, 32'd0, 1'b0, LD, 4'd0, 32'd0, 32'd0, 32'd0});

    for (int k = 0; k < NV; k++) do_step(VECS[k]);

    // idle cycle: no response may appear (R8)
    @(negedge clk);
    check("R8 ", "idle rsp_valid", {30'd0, rsp_valid}, 32'd0);

    // compare-and-swap: reserve, value matches expected 0, then swap (R2)
    do_step('{"R2 ", 1'b0, LD, 4'd0, 32'd0, 1'b1, LR, 4'd8, 32'd0, 32'd0, 32'd0});
    do_step('{"R2 ", 1'b0, LD, 4'd0, 32'd0, 1'b1, SC, 4'd8, 32'd55, 32'd0, OK});
    do_step('{"R2 ", 1'b1, LD, 4'd8, 32'd0, 1'b0, LD, 4'd0, 32'd0, 32'd55, 32'd0});

    // reset in the middle of a reserved sequence (R9)
    do_step('{"R9 ", 1'b1, LR, 4'd3, 32'd0, 1'b0, LD, 4'd0, 32'd0, 32'd7, 32'd0});
    #1 rst_ni = 1'b0;
    @(negedge clk);
    check("R9 ", "rsp_valid in reset", {30'd0, rsp_valid}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_step('{"R9 ", 1'b1, SC, 4'd3, 32'd99, 1'b0, LD, 4'd0, 32'd0, NG, 32'd0});
    do_step('{"R9 ", 1'b1, LD, 4'd3, 32'd0, 1'b1, LD, 4'd6, 32'd0, 32'd0, 32'd0});

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule